// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small bank of control registers on a simple memory-mapped bus. Each register has its own select line, and a single write strobe with a write-data word stores into the selected register. The bank holds:

- a configuration byte carrying a power-fail interrupt enable;
- a diagnostic byte and a modem-control byte;
- an auxiliary byte whose low bit fires a floppy terminal-count pulse;
- a power-down byte with a sticky power-fail status flag;
- a 32-bit system-control word that can request a system reset;
- a 16-bit LED word;
- a write-only idle register that strobes a CPU halt.

An external power-fail level feeds the status flag. The flag and the enable together drive a registered interrupt. Command bits written to the registers turn into single-cycle request pulses toward the rest of the chip: shutdown, system reset, CPU halt and terminal count. Block reset clears most of the bank. It keeps the diagnostic and system-control registers, so software can see after a reset what was there and why the reset happened.

Top module: `aux_sysctl`

## Requirements
- R1: `irq_o` is high exactly when the power-fail status flag (bit 5 of the power-down register) and the enable (bit 3 of the configuration register) are both 1. It changes on the same clock edge as either of them.
- R2: On a clock edge where `pwr_fail_i` differs from its value at the previous edge, the status flag takes the value `pwr_fail_i` AND the enable in effect before that edge. When the input has not changed, the flag holds, except as in R4. An input change takes priority over a clear written in the same cycle.
- R3: A write to the power-down register stores only data bits 1 and 0. Bit 5 reads as the status flag and is not writable. All other bits read 0.
- R4: Writing the power-down register with bit 1 set clears the status flag. Writing it with bit 0 set pulses `shutdown_o`.
- R5: Writing the system-control register with bit 0 set loads it with 0x00000002 and pulses `sys_reset_o`. A write with bit 0 clear stores the whole word.
- R6: Reset clears the configuration, modem-control, auxiliary, power-down and LED registers, the interrupt and all pulse outputs. The diagnostic and system-control registers keep their contents.
- R7: Writing the auxiliary register with bit 0 set pulses `fd_tc_o`. Bit 0 is never stored and reads 0. Bits 7..1 are stored.
- R8: Any write to the idle register pulses `cpu_halt_o`. The idle register reads 0.
- R9: Byte registers take `wdata[7:0]` and the LED register takes `wdata[15:0]`. Reads return the selected value zero-extended, with no side effects.
- R10: Each pulse output is high for exactly the one cycle after the clock edge that captures the causing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected register |
| sel_cfg | input | 1 | Selects the configuration register |
| sel_diag | input | 1 | Selects the diagnostic register |
| sel_modem | input | 1 | Selects the modem-control register |
| sel_aux | input | 1 | Selects the auxiliary register |
| sel_pwr | input | 1 | Selects the power-down register |
| sel_sys | input | 1 | Selects the system-control register |
| sel_led | input | 1 | Selects the LED register |
| sel_idle | input | 1 | Selects the idle register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| pwr_fail_i | input | 1 | External power-fail level |
| irq_o | output | 1 | Power-fail interrupt |
| fd_tc_o | output | 1 | Floppy terminal-count pulse |
| shutdown_o | output | 1 | Shutdown request pulse |
| sys_reset_o | output | 1 | System reset request pulse |
| cpu_halt_o | output | 1 | CPU halt strobe |

## Verification
The power-fail path is driven with these patterns:
- an input rise while enabled, which must set the flag;
- a rise while disabled, which must not set it;
- a steady high input after a software clear, where the flag must stay clear;
- disabling and re-enabling while the flag is set, where the interrupt must follow the enable but the flag must persist.

Together these separate level-following, edge-updating and enable-gated behaviour. Command writes are issued both with and without their trigger bit, so a pulse that fires on any write can be told apart from one that fires only on the bit. A mid-run reset checks which registers are cleared and which are retained.

// File: rtl/aux_sysctl.sv
module aux_sysctl #(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int LED_W   = 16,
  parameter int PF_BIT  = 5,
  parameter int EN_BIT  = 3,
  parameter int OFF_BIT = 0,
  parameter int CLR_BIT = 1,
  parameter int TC_BIT  = 0,
  parameter int RST_BIT = 0,
  parameter logic [DATA_W-1:0] RST_STAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_cfg,
  input  logic              sel_diag,
  input  logic              sel_modem,
  input  logic              sel_aux,
  input  logic              sel_pwr,
  input  logic              sel_sys,
  input  logic              sel_led,
  input  logic              sel_idle,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_fail_i,
  output logic              irq_o,
  output logic              fd_tc_o,
  output logic              shutdown_o,
  output logic              sys_reset_o,
  output logic              cpu_halt_o
);

  localparam int BPAD = DATA_W - BYTE_W;
  localparam int LPAD = DATA_W - LED_W;
  localparam logic [BYTE_W-1:0] PWR_KEEP = BYTE_W'((1 << OFF_BIT) | (1 << CLR_BIT));
  localparam logic [BYTE_W-1:0] TC_MASK  = BYTE_W'(1 << TC_BIT);

  logic [BYTE_W-1:0] cfg_q, diag_q, modem_q, aux_q, pwr_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] sys_q;
  logic              pf_stat, pf_q;

  wire w_cfg  = wr_en & sel_cfg;
  wire w_diag = wr_en & sel_diag;
  wire w_mdm  = wr_en & sel_modem;
  wire w_aux  = wr_en & sel_aux;
  wire w_pwr  = wr_en & sel_pwr;
  wire w_sys  = wr_en & sel_sys;
  wire w_led  = wr_en & sel_led;
  wire w_idle = wr_en & sel_idle;

  wire [BYTE_W-1:0] wbyte  = wdata[BYTE_W-1:0];
  wire              pf_chg = pwr_fail_i ^ pf_q;
  wire [BYTE_W-1:0] cfg_n  = w_cfg ? wbyte : cfg_q;

  logic stat_n;
  always_comb begin
    stat_n = pf_stat;
    if (pf_chg)                       stat_n = pwr_fail_i & cfg_q[EN_BIT];
    else if (w_pwr && wbyte[CLR_BIT]) stat_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      modem_q     <= '0;
      aux_q       <= '0;
      pwr_q       <= '0;
      led_q       <= '0;
      pf_stat     <= 1'b0;
      pf_q        <= 1'b0;
      irq_o       <= 1'b0;
      fd_tc_o     <= 1'b0;
      shutdown_o  <= 1'b0;
      sys_reset_o <= 1'b0;
      cpu_halt_o  <= 1'b0;
    end else begin
      cfg_q       <= cfg_n;
      pf_q        <= pwr_fail_i;
      pf_stat     <= stat_n;
      irq_o       <= stat_n & cfg_n[EN_BIT];
      if (w_mdm) modem_q <= wbyte;
      if (w_aux) aux_q   <= wbyte & ~TC_MASK;
      if (w_pwr) pwr_q   <= wbyte & PWR_KEEP;
      if (w_led) led_q   <= wdata[LED_W-1:0];
      fd_tc_o     <= w_aux & wbyte[TC_BIT];
      shutdown_o  <= w_pwr & wbyte[OFF_BIT];
      sys_reset_o <= w_sys & wdata[RST_BIT];
      cpu_halt_o  <= w_idle;
    end
  end

  always_ff @(posedge clk) begin
    if (w_diag) diag_q <= wbyte;
    if (w_sys)  sys_q  <= wdata[RST_BIT] ? RST_STAT : wdata;
  end

  logic [BYTE_W-1:0] pwr_rd;
  always_comb begin
    pwr_rd = pwr_q;
    pwr_rd[PF_BIT] = pf_stat;
  end

  always_comb begin
    rdata = '0;
    if (sel_cfg)        rdata = {{BPAD{1'b0}}, cfg_q};
    else if (sel_diag)  rdata = {{BPAD{1'b0}}, diag_q};
    else if (sel_modem) rdata = {{BPAD{1'b0}}, modem_q};
    else if (sel_aux)   rdata = {{BPAD{1'b0}}, aux_q};
    else if (sel_pwr)   rdata = {{BPAD{1'b0}}, pwr_rd};
    else if (sel_sys)   rdata = sys_q;
    else if (sel_led)   rdata = {{LPAD{1'b0}}, led_q};
  end

  // R1
  a_r1_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pf_stat & cfg_q[EN_BIT]));
  a_r2_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail_i && !pf_q && cfg_q[EN_BIT]) |=> pf_stat);
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (w_pwr && wbyte[CLR_BIT] && !pf_chg) |=> !pf_stat);
  a_r4_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (w_pwr && wbyte[OFF_BIT]) |=> shutdown_o);
  a_r5_sysreset: assert property (@(posedge clk) disable iff (!rst_n)
    (w_sys && wdata[RST_BIT]) |=> (sys_reset_o && sys_q == RST_STAT));
  a_r7_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (w_aux && wbyte[TC_BIT]) |=> fd_tc_o);
  a_r7_tc_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_q[TC_BIT]);
  a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
    w_idle |=> cpu_halt_o);
  a_r10_halt_single: assert property (@(posedge clk) disable iff (!rst_n)
    !w_idle |=> !cpu_halt_o);
  a_r10_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_aux && wbyte[TC_BIT]) |=> !fd_tc_o);
  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_cfg, sel_diag, sel_modem, sel_aux, sel_pwr, sel_sys, sel_led, sel_idle}));

endmodule

// File: tb/test_aux_sysctl.sv
module test_aux_sysctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic pwr_fail = 1'b0;
  logic irq, tc, shut, srst, halt;

  always #5 clk = ~clk;

  aux_sysctl i_aux_sysctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .sel_cfg(sel[0]), .sel_diag(sel[1]), .sel_modem(sel[2]), .sel_aux(sel[3]),
    .sel_pwr(sel[4]), .sel_sys(sel[5]), .sel_led(sel[6]), .sel_idle(sel[7]),
    .wdata(wdata), .rdata(rdata), .pwr_fail_i(pwr_fail),
    .irq_o(irq), .fd_tc_o(tc), .shutdown_o(shut), .sys_reset_o(srst), .cpu_halt_o(halt)
  );

  localparam int CFG = 0, DIAG = 1, MDM = 2, AUX = 3, PWR = 4, SYS = 5, LED = 6, IDLE = 7;
  localparam int OUTS = 8;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // outputs packed as {irq, tc, shutdown, sys_reset, halt}
  always begin
    @(negedge clk);
    #2;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == OUTS) ? {27'b0, irq, tc, shut, srst, halt} : rdata;
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input int code, input logic [31:0] d);
    @(negedge clk);
    sel = '0; sel[code] = 1'b1; wr_en = 1'b1; wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    sel = '0; wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int code, input logic [31:0] e, input string tag);
    @(negedge clk);
    sel = '0; sel[code] = 1'b1; wr_en = 1'b0;
    q.push_back('{cyc, code, e, tag});
  endtask

  task automatic expout(input logic [31:0] e, input string tag);
    q.push_back('{cyc + 1, OUTS, e, tag});
  endtask

  task automatic setpf(input logic v);
    @(negedge clk);
    sel = '0; wr_en = 1'b0; pwr_fail = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sel = '0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(IDLE, 32'h0, "R6 outputs idle after reset"); expout(32'h0, "R6 outputs clear after reset");

    wr(CFG, 32'hFF); wr(MDM, 32'h3C); wr(AUX, 32'hF0); wr(DIAG, 32'hA5);
    wr(SYS, 32'h1234_5670); wr(LED, 32'hBEEF);
    rd(CFG, 32'hFF, "R9 cfg"); rd(MDM, 32'h3C, "R9 modem"); rd(AUX, 32'hF0, "R7 aux");
    rd(DIAG, 32'hA5, "R9 diag"); rd(SYS, 32'h1234_5670, "R5 sys plain store");
    rd(LED, 32'hBEEF, "R9 led");

    do_reset();
    rd(CFG, 32'h0, "R6 cfg cleared"); rd(MDM, 32'h0, "R6 modem cleared");
    rd(AUX, 32'h0, "R6 aux cleared"); rd(PWR, 32'h0, "R6 pwr cleared");
    rd(LED, 32'h0, "R6 led cleared");
    rd(DIAG, 32'hA5, "R6 diag kept"); rd(SYS, 32'h1234_5670, "R6 sys kept");

    wr(AUX, 32'h5B); expout(32'h08, "R7 tc pulse");
    idle(); expout(32'h0, "R10 tc one cycle");
    rd(AUX, 32'h5A, "R7 tc bit not stored");

    wr(CFG, 32'h08); expout(32'h0, "R1 enable alone no irq");
    setpf(1'b1); expout(32'h10, "R2 rise sets flag irq");
    rd(PWR, 32'h20, "R3 status bit 5");

    wr(PWR, 32'hFE); expout(32'h0, "R4 clear drops irq");
    rd(PWR, 32'h02, "R3 only bits 1..0 stored");
    wr(PWR, 32'h01); expout(32'h04, "R4 shutdown pulse");
    idle(); expout(32'h0, "R10 shutdown one cycle");
    rd(PWR, 32'h01, "R2 steady input no reset of flag");
    rd(PWR, 32'h01, "R9 read no side effect");

    setpf(1'b0); expout(32'h0, "R2 fall");
    wr(CFG, 32'h00); expout(32'h0, "R1 disabled");
    setpf(1'b1); expout(32'h0, "R2 rise while disabled");
    rd(PWR, 32'h01, "R2 flag not set when disabled");
    wr(CFG, 32'h08); expout(32'h0, "R1 enable with flag clear");
    setpf(1'b0); expout(32'h0, "R2 fall enabled");
    setpf(1'b1); expout(32'h10, "R2 rise enabled");
    wr(CFG, 32'h00); expout(32'h0, "R1 irq drops with enable");
    rd(PWR, 32'h21, "R1 flag sticky while disabled");
    wr(CFG, 32'h08); expout(32'h10, "R1 irq returns with enable");
    wr(PWR, 32'h02); expout(32'h0, "R4 clear");
    rd(PWR, 32'h02, "R4 flag cleared");

    wr(SYS, 32'hFF); expout(32'h02, "R5 reset pulse");
    idle(); expout(32'h0, "R10 reset one cycle");
    rd(SYS, 32'h2, "R5 reset status");
    wr(SYS, 32'hCAFE_0000); expout(32'h0, "R5 no pulse bit0 clear");
    rd(SYS, 32'hCAFE_0000, "R5 word stored");

    wr(IDLE, 32'h77); expout(32'h01, "R8 halt pulse");
    idle(); expout(32'h0, "R10 halt one cycle");
    rd(IDLE, 32'h0, "R8 idle reads zero");

    wr(LED, 32'h1234_ABCD); rd(LED, 32'hABCD, "R9 led width");
    wr(DIAG, 32'h1FF); rd(DIAG, 32'hFF, "R9 diag width");
    wr(MDM, 32'h281); rd(MDM, 32'h81, "R9 modem width");

    idle();
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL queue: actual %0d left expected 0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule